// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of up to 32 general-purpose pins behind a small memory-mapped register window. Each pin has seven control bits: output value, interrupt mask, pull-disable, alternate-function enable, alternate-function select, direction and trigger type. Every control register can be written whole. It can also be changed through a write-one-to-set alias and a write-one-to-clear alias, so software can change single bits without a read-modify-write cycle.

The pin inputs pass through a synchroniser. The synchronised levels can be read back at any time. When a pin is configured as an interrupt source, the direction bit gives the polarity and the trigger bit chooses between edge and level detection. A detected condition is latched into a sticky flag register. The OR of all flags drives a single interrupt line toward a parent controller, and a second output gives the index of the lowest pending flag so a dispatcher can find the source without scanning. A bank may implement fewer than 32 pins. The missing positions read as zero and never raise a flag.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, except the mask register, which reads ones on all implemented bits. The interrupt output is low and the index output is 0.
- R2: A write to a register's base offset (data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70) replaces all implemented bits, and a read of that offset returns the register.
- R3: A write at base+0x4 sets the bits written as one. A write at base+0x8 clears the bits written as one. Bits written as zero keep their value.
- R4: A read of offset 0x00 returns the synchronised level of every implemented pin, whatever the pin's direction. A pin change becomes visible after two clock edges.
- R5: With trigger=1, direction=1 detects a rising edge and direction=0 detects a falling edge. An edge is found by comparing two successive synchronised samples. The flag is readable at 0x80 three edges after the pin changes. The opposite edge sets nothing.
- R6: With trigger=0, direction=1 detects a high level and direction=0 detects a low level. The flag is set again on every cycle in which the level holds.
- R7: A pin can set its flag only when its mask bit is 0, its select bit is 1 and its function bit is 0. A mask bit of 1 blocks the pin.
- R8: Flags are sticky. Writing ones to 0x84 clears those flags. If a flag is set and cleared in the same cycle, the set wins. A direct write to 0x80 has no effect.
- R9: `irq_o` is the OR of all flags, one cycle later. `irq_idx` is the index of the lowest set flag, or 0 when no flag is set.
- R10: Bit positions at or above PIN_COUNT read as zero in every register and in the pin register, and never raise a flag.
- R11: `pad_out` follows the data register. `pull_off`, `alt_en` and `alt_sel` follow the pull, function and select registers. `pad_oe` is direction AND NOT function AND NOT select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset in the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| pull_off | output | 32 | Pull resistor disable per pin |
| alt_en | output | 32 | Alternate-function enable per pin |
| alt_sel | output | 32 | Alternate-function select per pin |
| irq_o | output | 1 | Combined bank interrupt |
| irq_idx | output | 5 | Lowest pending flag index |

## Verification
A control bit stored wrongly shows up at once on the pad outputs and on the next read of its offset, so every alias write is read back at once. A wrong synchroniser or edge stage moves the flag by a cycle, or makes it appear on the wrong edge. The bench therefore samples the flag register on the exact edge where it must first appear, and on the edge before it. A stuck flag or a wrong priority shows up on `irq_o` one cycle after a clear, or as a wrong `irq_idx` right after the lower flag is cleared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W   = 32;
    localparam int OFS_W    = 8;
    localparam int NUM_CTRL = 7;
    localparam int IDX_W    = $clog2(WORD_W);

    // upper nibble of the offset picks the register group
    typedef enum logic [3:0] {
        GRP_PIN  = 4'h0,
        GRP_DATA = 4'h1,
        GRP_MASK = 4'h2,
        GRP_PULL = 4'h3,
        GRP_FUNC = 4'h4,
        GRP_SEL  = 4'h5,
        GRP_DIR  = 4'h6,
        GRP_TRIG = 4'h7,
        GRP_FLAG = 4'h8
    } grp_e;

    // lower nibble picks the access kind
    localparam logic [3:0] OP_BASE = 4'h0;
    localparam logic [3:0] OP_HI   = 4'h4;
    localparam logic [3:0] OP_LO   = 4'h8;

    function automatic logic [WORD_W-1:0] impl_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(lvl_o)));  // R5

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] pin_lvl,
    input  logic [WORD_W-1:0] flag_lvl,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] pull_o,
    output logic [WORD_W-1:0] func_o,
    output logic [WORD_W-1:0] sel_o,
    output logic [WORD_W-1:0] dir_o,
    output logic [WORD_W-1:0] trig_o,
    output logic [WORD_W-1:0] flag_clr_o
);

    localparam logic [WORD_W-1:0] IMPL = impl_mask(PIN_COUNT);
    localparam int MASK_IDX = int'(GRP_MASK) - 1;

    typedef struct packed {
        logic [NUM_CTRL-1:0][WORD_W-1:0] r;
    } regs_t;

    regs_t      cr_d, cr_q;
    logic [3:0] grp;
    logic [3:0] op;

    assign grp = addr[7:4];
    assign op  = addr[3:0];

    // next-state: one group matches at most
    always_comb begin
        cr_d = cr_q;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (wr_en && grp == 4'(i + 1)) begin
                case (op)
                    OP_BASE: cr_d.r[i] = wdata & IMPL;
                    OP_HI:   cr_d.r[i] = cr_q.r[i] | (wdata & IMPL);
                    OP_LO:   cr_d.r[i] = cr_q.r[i] & ~wdata;
                    default: cr_d.r[i] = cr_q.r[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q             <= '0;
            cr_q.r[MASK_IDX] <= IMPL;
        end else begin
            cr_q <= cr_d;
        end
    end

    // flag clearing lives at the flag group's high alias
    assign flag_clr_o = (wr_en && grp == GRP_FLAG && op == OP_HI) ? (wdata & IMPL) : '0;

    always_comb begin
        rdata = '0;
        if (op == OP_BASE) begin
            if (grp == GRP_PIN)
                rdata = pin_lvl & IMPL;
            else if (grp == GRP_FLAG)
                rdata = flag_lvl;
            else if (grp <= GRP_TRIG)
                rdata = cr_q.r[grp - 4'd1];
        end
    end

    assign data_o = cr_q.r[int'(GRP_DATA) - 1];
    assign mask_o = cr_q.r[int'(GRP_MASK) - 1];
    assign pull_o = cr_q.r[int'(GRP_PULL) - 1];
    assign func_o = cr_q.r[int'(GRP_FUNC) - 1];
    assign sel_o  = cr_q.r[int'(GRP_SEL)  - 1];
    assign dir_o  = cr_q.r[int'(GRP_DIR)  - 1];
    assign trig_o = cr_q.r[int'(GRP_TRIG) - 1];

    AST_HI_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h24) |=> ((mask_o & $past(wdata & IMPL)) == $past(wdata & IMPL)));  // R3
    AST_LO_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h28) |=> ((mask_o & $past(wdata)) == '0));  // R3
    AST_LO_ALIAS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h28) |=> ((mask_o & ~$past(wdata)) == ($past(mask_o) & ~$past(wdata))));  // R3
    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata & ~IMPL) == '0));  // R10

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] lvl_i,
    input  logic [WORD_W-1:0] prev_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [WORD_W-1:0] sel_i,
    input  logic [WORD_W-1:0] func_i,
    input  logic [WORD_W-1:0] dir_i,
    input  logic [WORD_W-1:0] trig_i,
    input  logic [WORD_W-1:0] clr_i,
    output logic [WORD_W-1:0] flag_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [WORD_W-1:0] IMPL = impl_mask(PIN_COUNT);

    typedef struct packed {
        logic [WORD_W-1:0] flag;
        logic              irq;
    } det_t;

    det_t              dt_d, dt_q;
    logic [WORD_W-1:0] cond;
    logic [WORD_W-1:0] set_vec;

    // per-pin condition: trigger picks edge/level, direction picks polarity
    for (genvar g = 0; g < WORD_W; g++) begin : g_pin
        if (g < PIN_COUNT) begin : g_live
            logic rise, fall;
            assign rise = lvl_i[g] & ~prev_i[g];
            assign fall = ~lvl_i[g] & prev_i[g];
            always_comb begin
                case ({trig_i[g], dir_i[g]})
                    2'b11:   cond[g] = rise;
                    2'b10:   cond[g] = fall;
                    2'b01:   cond[g] = lvl_i[g];
                    default: cond[g] = ~lvl_i[g];
                endcase
            end
        end else begin : g_absent
            assign cond[g] = 1'b0;
        end
    end

    assign set_vec = cond & ~mask_i & sel_i & ~func_i & IMPL;

    always_comb begin
        dt_d      = dt_q;
        dt_d.flag = (dt_q.flag & ~clr_i) | set_vec;
        dt_d.irq  = |dt_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dt_q <= '0;
        else        dt_q <= dt_d;
    end

    always_comb begin
        idx_o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (dt_q.flag[i]) idx_o = IDX_W'(i);
        end
    end

    assign flag_o = dt_q.flag;
    assign irq_o  = dt_q.irq;

    AST_MASKED_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & ~$past(flag_o) & $past(mask_i)) == '0));  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_o & $past(set_vec)) == $past(set_vec)));  // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_vec) != '0) |=> ((flag_o & $past(clr_i & ~set_vec)) == '0));  // R8
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|flag_o)));  // R9
    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_o) |-> (flag_o[idx_o] && ((flag_o & ((32'd1 << idx_o) - 32'd1)) == '0)));  // R9

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe,
    output logic [31:0] pull_off,
    output logic [31:0] alt_en,
    output logic [31:0] alt_sel,
    output logic        irq_o,
    output logic [4:0]  irq_idx
);

    logic [WORD_W-1:0] lvl, prev, flag, clr;
    logic [WORD_W-1:0] data_r, mask_r, pull_r, func_r, sel_r, dir_r, trig_r;

    gpio_pin_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    gpio_ctrl_regs #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .pin_lvl    (lvl),
        .flag_lvl   (flag),
        .rdata      (bus_rdata),
        .data_o     (data_r),
        .mask_o     (mask_r),
        .pull_o     (pull_r),
        .func_o     (func_r),
        .sel_o      (sel_r),
        .dir_o      (dir_r),
        .trig_o     (trig_r),
        .flag_clr_o (clr)
    );

    gpio_irq_detect #(.PIN_COUNT(PIN_COUNT)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .prev_i (prev),
        .mask_i (mask_r),
        .sel_i  (sel_r),
        .func_i (func_r),
        .dir_i  (dir_r),
        .trig_i (trig_r),
        .clr_i  (clr),
        .flag_o (flag),
        .irq_o  (irq_o),
        .idx_o  (irq_idx)
    );

    assign pad_out  = data_r;
    assign pad_oe   = dir_r & ~func_r & ~sel_r;
    assign pull_off = pull_r;
    assign alt_en   = func_r;
    assign alt_sel  = sel_r;

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

    localparam int          NPIN = 31;
    localparam logic [31:0] IMPL = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, pull_off, alt_en, alt_sel;
    logic        irq_o;
    logic [4:0]  irq_idx;

    int errors = 0;
    int checks = 0;
    logic [31:0] mreg [1:7];

    gpio_bank #(.PIN_COUNT(NPIN), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_off(pull_off),
        .alt_en(alt_en), .alt_sel(alt_sel), .irq_o(irq_o), .irq_idx(irq_idx)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_val(input logic [31:0] old, input logic [3:0] op,
                                             input logic [31:0] d);
        case (op)
            4'h0:    return d & IMPL;
            4'h4:    return old | (d & IMPL);
            4'h8:    return old & ~d;
            default: return old;
        endcase
    endfunction

    function automatic logic [31:0] exp_oe();
        return mreg[6] & ~mreg[4] & ~mreg[5];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        if (a[7:4] >= 4'd1 && a[7:4] <= 4'd7)
            mreg[a[7:4]] = next_val(mreg[a[7:4]], a[3:0], d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0; bus_wr = 1'b0;
        for (int i = 1; i <= 7; i++) mreg[i] = '0;
        mreg[2] = IMPL;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // make a pin an unmasked interrupt source of the given type, then drop stale flags
    task automatic cfg_irq(input int p, input logic dir, input logic trig);
        wr(dir  ? 8'h64 : 8'h68, 32'd1 << p);
        wr(trig ? 8'h74 : 8'h78, 32'd1 << p);
        wr(8'h54, 32'd1 << p);
        wr(8'h48, 32'd1 << p);
        wr(8'h28, 32'd1 << p);
        repeat (4) @(negedge clk);
        wr(8'h84, 32'hFFFF_FFFF);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        for (int g = 1; g <= 8; g++) begin
            rd(8'(g << 4), v);
            chk("R1 reset value", v, (g == 2) ? IMPL : 32'h0);
        end
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 idx after reset", {27'd0, irq_idx}, 32'd0);

        // R2 R3 R10 R11 random register traffic with alias model
        for (int n = 0; n < 300; n++) begin
            logic [3:0] g;
            logic [3:0] op;
            logic [31:0] d;
            g  = 4'($urandom_range(1, 7));
            op = 4'($urandom_range(0, 2) * 4);
            d  = $urandom;
            wr({g, op}, d);
            rd({g, 4'h0}, v);
            chk(op == 4'h0 ? "R2 direct write" : "R3 alias write", v, mreg[g]);
            chk("R10 unimplemented reads zero", v & ~IMPL, 32'h0);
            chk("R11 pad_out", pad_out, mreg[1]);
            chk("R11 pad_oe", pad_oe, exp_oe());
            chk("R11 pull/func/sel", pull_off ^ alt_en ^ alt_sel, mreg[3] ^ mreg[4] ^ mreg[5]);
        end

        // R4 pin readback with two-edge latency
        for (int n = 0; n < 30; n++) begin
            logic [31:0] p;
            p = $urandom;
            @(negedge clk);
            pin_in = p;
            bus_addr = 8'h00;
            @(posedge clk);
            @(negedge clk);
            #1 if (n > 0) chk("R4 not yet visible after one edge", 32'(bus_rdata != (p & IMPL) || p == pin_in), 32'd1);
            @(posedge clk);
            @(negedge clk);
            #1 chk("R4 pin level R10 bit31", bus_rdata, p & IMPL);
        end

        // R5 rising edge on pin 5, exact latency, R9 irq lag and index
        do_reset();
        cfg_irq(5, 1'b1, 1'b1);
        @(negedge clk);
        pin_in[5] = 1'b1;
        bus_addr = 8'h80;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1 chk("R5 no flag after two edges", bus_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R5 rising flag on third edge", bus_rdata, 32'h20);
        chk("R9 irq still low", {31'd0, irq_o}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R9 irq one cycle later", {31'd0, irq_o}, 32'd1);
        chk("R9 idx pin5", {27'd0, irq_idx}, 32'd5);
        wr(8'h80, 32'h0);
        rd(8'h80, v);
        chk("R8 direct write to flag ignored", v, 32'h20);
        wr(8'h84, 32'h20);
        rd(8'h80, v);
        chk("R8 clear alias (edge gone)", v, 32'h0);
        wait_cycles(1);
        chk("R9 irq drops", {31'd0, irq_o}, 32'd0);

        // R5 falling edge on pin 9: rise ignored, fall flags
        cfg_irq(9, 1'b0, 1'b1);
        @(negedge clk); pin_in[9] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R5 falling type ignores rise", v & 32'h200, 32'h0);
        @(negedge clk); pin_in[9] = 1'b0;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R5 falling flag", v & 32'h200, 32'h200);
        wr(8'h84, 32'hFFFF_FFFF);

        // R6 level high on pin 3, set wins over clear
        do_reset();
        cfg_irq(3, 1'b1, 1'b0);
        rd(8'h80, v);
        chk("R6 level high idle", v, 32'h0);
        @(negedge clk); pin_in[3] = 1'b1;
        wait_cycles(4);
        rd(8'h80, v);
        chk("R6 level high flag", v, 32'h8);
        wr(8'h84, 32'h8);
        rd(8'h80, v);
        chk("R6 R8 set wins while level holds", v, 32'h8);
        @(negedge clk); pin_in[3] = 1'b0;
        wait_cycles(4);
        wr(8'h84, 32'h8);
        rd(8'h80, v);
        chk("R8 cleared once level gone", v, 32'h0);
        wait_cycles(1);
        chk("R9 irq low after clear", {31'd0, irq_o}, 32'd0);

        // R6 level low on pin 12: flags at once while low
        @(negedge clk); pin_in[12] = 1'b1;
        wait_cycles(4);
        cfg_irq(12, 1'b0, 1'b0);
        rd(8'h80, v);
        chk("R6 level low idle while high", v, 32'h0);
        @(negedge clk); pin_in[12] = 1'b0;
        wait_cycles(4);
        rd(8'h80, v);
        chk("R6 level low flag", v, 32'h1000);

        // R7 mask, function and select gating on pin 7
        do_reset();
        cfg_irq(7, 1'b1, 1'b1);
        wr(8'h24, 32'h80);
        @(negedge clk); pin_in[7] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R7 masked pin no flag", v, 32'h0);
        @(negedge clk); pin_in[7] = 1'b0;
        wait_cycles(4);
        wr(8'h28, 32'h80);
        wr(8'h44, 32'h80);
        @(negedge clk); pin_in[7] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R7 function pin no flag", v, 32'h0);
        @(negedge clk); pin_in[7] = 1'b0;
        wait_cycles(4);
        wr(8'h48, 32'h80);
        wr(8'h58, 32'h80);
        @(negedge clk); pin_in[7] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R7 unselected pin no flag", v, 32'h0);

        // R9 lowest index with two pending flags
        do_reset();
        cfg_irq(20, 1'b1, 1'b1);
        cfg_irq(6, 1'b1, 1'b1);
        @(negedge clk); pin_in[20] = 1'b1; pin_in[6] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R9 both flags", v, 32'h0010_0040);
        chk("R9 idx lowest 6", {27'd0, irq_idx}, 32'd6);
        wr(8'h84, 32'h40);
        #1 chk("R9 idx moves to 20", {27'd0, irq_idx}, 32'd20);
        chk("R9 irq held", {31'd0, irq_o}, 32'd1);
        wr(8'h84, 32'h0010_0000);
        wait_cycles(1);
        chk("R9 irq low none pending", {31'd0, irq_o}, 32'd0);
        chk("R9 idx zero none pending", {27'd0, irq_idx}, 32'd0);

        // R10 missing pin 31
        do_reset();
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wait_cycles(4);
        @(negedge clk); pin_in[31] = 1'b1;
        wait_cycles(5);
        rd(8'h80, v);
        chk("R10 missing pin never flags", v, 32'h0);
        rd(8'h00, v);
        chk("R10 missing pin reads zero", v, 32'h0);
        rd(8'h60, v);
        chk("R10 direction top bit zero", v, IMPL);
        chk("R10 irq quiet", {31'd0, irq_o}, 32'd0);

        summary();
    end

endmodule